// File: doc/BRIEF.md
# Receive Control Character Detector

This block sits on the receive side of a byte-wide parallel port. Every byte that arrives with a strobe is compared against a small programmable table of control characters. Before the comparison, the received byte and each table entry are both filtered through a shared bit mask. A byte that matches an entry marked for rejection never reaches the data buffer. The byte is captured in a single received-control-character holding register and raises a rejection event. A byte that matches an entry not marked for rejection is still forwarded, and it raises a separate accepted-match event. Bytes that match nothing are forwarded unchanged.

Software programs the table, the compare mask and the interrupt mask through a simple write port. It reads them back, together with the event bits and the holding register, through a combinational read port. Event bits are sticky and are cleared by writing a 1 to them. The interrupt output is the OR of the enabled events. The holding register keeps no queue: a newer rejected character simply replaces the older one.

Top module: `ctlchar_filter`

## Requirements
- R1: After reset all table entries read 0 (invalid), the mask reads 0x00FF, the event, interrupt-mask and holding registers read 0, and both irq and buf_vld are low.
- R2: A strobed byte that matches no entry appears on buf_byte with buf_vld high in the cycle after the strobe, for that one cycle only, and sets no event.
- R3: A strobed byte whose first match has its reject bit set (entry bit 14) is not forwarded. It is stored in the holding register (address 11, bits 7:0) and sets event bit 0.
- R4: A strobed byte whose first match has its reject bit clear is forwarded as in R2 and sets event bit 1.
- R5: A mask bit of 1 (address 8, bits 7:0) makes that bit position take part in the comparison. A mask bit of 0 makes it don't-care for every entry.
- R6: Entries are searched from address 0 upward. The first entry whose valid bit (bit 15) is clear ends the search, so no entry beyond it can match.
- R7: When several valid entries match, the lowest-addressed one decides whether the byte is rejected.
- R8: A rejected byte that arrives before the holding register has been read overwrites the previous value.
- R9: Event bits (address 9: bit 0 rejected, bit 1 accepted) stay set until a write of 1 to that bit. Writing 0 leaves a bit unchanged. A new event in the same cycle as its clear leaves the bit set.
- R10: irq is high exactly when some event bit is set and the same bit in the interrupt mask (address 10, bits 1:0) is 1.
- R11: Writes to addresses 0 to 7 (bit 15 valid, bit 14 reject, bits 7:0 character), 8 and 10 read back through rd_data at the same address in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_stb | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| buf_vld | output | 1 | Forwarded byte valid |
| buf_byte | output | 8 | Forwarded byte to the buffer path |
| irq | output | 1 | Interrupt request |

## Verification
All of this block's results are due at the first clock edge that samples the strobe. Forwarding, the holding-register capture and the event bits are therefore visible one edge after the strobe. irq follows the event and mask registers with no further delay. The bench drives the strobe and register writes on falling edges and looks at outputs on the next falling edge, shortly after changing rd_addr. Each check lands between the edge that produced the result and the edge that could change it again.

// File: rtl/ctlchar_filter.sv
module ctlchar_filter #(
  parameter int ENTRIES = 8,
  parameter int W       = 8,
  parameter int AW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_stb,
  input  logic [W-1:0]  rx_byte,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  output logic          buf_vld,
  output logic [W-1:0]  buf_byte,
  output logic          irq
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AW-1:0] A_MASK = AW'(ENTRIES);
  localparam logic [AW-1:0] A_EVT  = AW'(ENTRIES + 1);
  localparam logic [AW-1:0] A_IMSK = AW'(ENTRIES + 2);
  localparam logic [AW-1:0] A_HOLD = AW'(ENTRIES + 3);

  logic [W-1:0]       tchar [ENTRIES];
  logic [ENTRIES-1:0] tval, trej;
  logic [W-1:0]       mask, hold;
  logic [1:0]         ev, imsk, ev_set, ev_clr;
  logic               hit, hit_rej;

  always_comb begin
    logic live;
    live    = 1'b1;
    hit     = 1'b0;
    hit_rej = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (live) begin
        if (!tval[i]) live = 1'b0;
        else if (((tchar[i] ^ rx_byte) & mask) == '0) begin
          hit     = 1'b1;
          hit_rej = trej[i];
          live    = 1'b0;
        end
      end
    end
  end

  assign ev_set = {rx_stb & hit & ~hit_rej, rx_stb & hit & hit_rej};
  assign ev_clr = (wr_en && wr_addr == A_EVT) ? wr_data[1:0] : 2'b00;
  assign irq    = |(ev & imsk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tchar[i] <= '0;
      tval     <= '0;
      trej     <= '0;
      mask     <= '1;
      imsk     <= '0;
      ev       <= '0;
      hold     <= '0;
      buf_vld  <= 1'b0;
      buf_byte <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_en && wr_addr == AW'(i)) begin
          tchar[i] <= wr_data[W-1:0];
          tval[i]  <= wr_data[15];
          trej[i]  <= wr_data[14];
        end
      end
      if (wr_en && wr_addr == A_MASK) mask <= wr_data[W-1:0];
      if (wr_en && wr_addr == A_IMSK) imsk <= wr_data[1:0];
      ev <= (ev & ~ev_clr) | ev_set;
      if (ev_set[0]) hold <= rx_byte;
      buf_vld <= rx_stb & ~(hit & hit_rej);
      if (rx_stb) buf_byte <= rx_byte;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < A_MASK) begin
      rd_data[15]    = tval[rd_addr[IW-1:0]];
      rd_data[14]    = trej[rd_addr[IW-1:0]];
      rd_data[W-1:0] = tchar[rd_addr[IW-1:0]];
    end else if (rd_addr == A_MASK) rd_data[W-1:0] = mask;
    else if (rd_addr == A_EVT)  rd_data[1:0]   = ev;
    else if (rd_addr == A_IMSK) rd_data[1:0]   = imsk;
    else if (rd_addr == A_HOLD) rd_data[W-1:0] = hold;
  end

  a_r2_forward_next: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb && !(hit && hit_rej) |=> buf_vld && buf_byte == $past(rx_byte));
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_stb |=> !buf_vld);
  a_r3_reject_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb && hit && hit_rej |=> !buf_vld && hold == $past(rx_byte) && ev[0]);
  a_r4_accept_event: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stb && hit && !hit_rej |=> ev[1] && buf_vld);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] && !(wr_en && wr_addr == A_EVT && wr_data[0]) |=> ev[0]);
  a_r9_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev[1]) |-> $past(rx_stb));
endmodule

// File: tb/test_ctlchar_filter.sv
module test_ctlchar_filter;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx_stb = 1'b0, wr_en = 1'b0;
  logic [7:0]  rx_byte = '0, buf_byte;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic        buf_vld, irq;
  int errors = 0, checks = 0;
  logic [7:0] exp_hold = '0;

  ctlchar_filter i_ctlchar_filter (.*);

  always #4 clk = ~clk;

  // {byte, forwarded, events[1:0]} with mask 0xFF
  localparam logic [10:0] VEC [7] = '{
    {8'h41, 1'b1, 2'b00},
    {8'h1B, 1'b0, 2'b01},
    {8'h0A, 1'b1, 2'b10},
    {8'h55, 1'b1, 2'b00},
    {8'h40, 1'b0, 2'b01},
    {8'h00, 1'b1, 2'b00},
    {8'h4F, 1'b1, 2'b00}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); rx_stb = 1'b1; rx_byte = b;
    @(negedge clk); rx_stb = 1'b0;
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rd(4'd0, d);  check("R1 entry0", d, 16'h0000);
    rd(4'd8, d);  check("R1 mask", d, 16'h00FF);
    rd(4'd9, d);  check("R1 events", d, 16'h0000);
    rd(4'd10, d); check("R1 imask", d, 16'h0000);
    rd(4'd11, d); check("R1 hold", d, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0);
    check("R1 buf_vld", {15'b0, buf_vld}, 16'h0);
    rst_n = 1'b1;

    wr(4'd0, 16'hC01B);
    wr(4'd1, 16'h800A);
    wr(4'd2, 16'hC00A);
    wr(4'd3, 16'hC040);
    wr(4'd4, 16'h0000);
    wr(4'd5, 16'hC055);
    rd(4'd0, d); check("R11 entry0 readback", d, 16'hC01B);
    rd(4'd1, d); check("R11 entry1 readback", d, 16'h800A);

    // R2 R3 R4 R6 R7 vector walk
    for (int k = 0; k < 7; k++) begin
      send(VEC[k][10:3]);
      check("R2/R3/R4 buf_vld", {15'b0, buf_vld}, {15'b0, VEC[k][2]});
      if (VEC[k][2]) check("R2 buf_byte", {8'h0, buf_byte}, {8'h0, VEC[k][10:3]});
      else exp_hold = VEC[k][10:3];
      rd(4'd9, d);  check("R3/R4/R6/R7 events", d, {14'b0, VEC[k][1:0]});
      rd(4'd11, d); check("R3 hold", d, {8'h0, exp_hold});
      @(negedge clk);
      check("R2 one-cycle valid", {15'b0, buf_vld}, 16'h0);
      wr(4'd9, 16'h0003);
    end

    // R5 mask: compare only upper nibble
    wr(4'd8, 16'h00F0);
    rd(4'd8, d); check("R11 mask readback", d, 16'h00F0);
    send(8'h4F);
    check("R5 masked reject", {15'b0, buf_vld}, 16'h0);
    rd(4'd11, d); check("R5 hold", d, 16'h004F);
    send(8'h0F);
    check("R5 masked accept fwd", {15'b0, buf_vld}, 16'h1);
    rd(4'd9, d); check("R5 events", d, 16'h0003);
    wr(4'd9, 16'h0003);
    wr(4'd8, 16'h00FF);

    // R8 overwrite
    send(8'h1B); send(8'h40);
    rd(4'd11, d); check("R8 overwrite", d, 16'h0040);

    // R9 sticky and write-1-clear
    wr(4'd9, 16'h0000);
    rd(4'd9, d); check("R9 write 0 keeps", d, 16'h0001);
    wr(4'd9, 16'h0002);
    rd(4'd9, d); check("R9 other bit keeps", d, 16'h0001);

    // R10 irq masking
    check("R10 irq masked off", {15'b0, irq}, 16'h0);
    wr(4'd10, 16'h0002);
    rd(4'd10, d); check("R11 imask readback", d, 16'h0002);
    check("R10 irq wrong bit", {15'b0, irq}, 16'h0);
    wr(4'd10, 16'h0001);
    check("R10 irq enabled", {15'b0, irq}, 16'h1);

    wr(4'd9, 16'h0001);
    rd(4'd9, d); check("R9 cleared", d, 16'h0000);
    check("R10 irq after clear", {15'b0, irq}, 16'h0);

    // R9 set beats clear in the same cycle
    @(negedge clk);
    rx_stb = 1'b1; rx_byte = 8'h1B;
    wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'h0001;
    @(negedge clk);
    rx_stb = 1'b0; wr_en = 1'b0;
    rd(4'd9, d); check("R9 set wins", d, 16'h0001);
    check("R10 irq on set", {15'b0, irq}, 16'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule